// File: doc/BRIEF.md
# Host Bus Response Encoder

This block picks the response-phase code that a host bridge returns for each processor bus transaction. Each cycle it may be given a transaction description. The description carries the direction, a zero-length flag, the target class, a lock flag, the snoop result for a modified line, a flag that the target is busy, and an enable for deferral. One clock later the block returns a 3-bit response code together with a valid strobe.

The code is chosen by a fixed priority. A retry wins when the target is busy and the transaction may be retried. An implicit writeback follows when the snoop hit a modified line. A deferral follows when deferral is enabled and the transaction may be deferred. Otherwise the transaction gets a no-data or normal-data response. Codes are logical values, not active-low pin levels.

Top module: `host_resp_enc`

## Requirements
- R1: One clock after a cycle with `req_valid_i` high, `resp_valid_o` is high and `resp_code_o` carries the response. One clock after a cycle with `req_valid_i` low, `resp_valid_o` is low and `resp_code_o` is 000 (idle). During reset both are zero.
- R2: The codes 011 (reserved) and 100 (hard failure) never appear on `resp_code_o`.
- R3: Target encodings are 0 DRAM, 1 PCI memory, 2 PCI I/O, 3 interrupt acknowledge, 4 AGP memory and 5 AGP I/O. Values 6 and 7 are treated like DRAM without the locked-read rule. When `target_busy_i` is high, the code is 001 (retry) for any read or write to targets 1 to 5, and for a locked read of DRAM.
- R4: A busy target that may not be retried (DRAM writes, unlocked DRAM reads, targets 6 and 7) does not produce retry. The normal priority selection applies instead.
- R5: When no retry is issued and `snoop_hitm_i` is high, the code is 110 (implicit writeback), whatever the deferral enable is.
- R6: When there is no retry and no snoop hit, and `defer_en_i` is high, the code is 010 (deferred) for these cases: reads of targets 1 to 5, and writes to targets 2 and 5.
- R7: A transaction that may not be deferred (a write to target 1 or 4, or any access to DRAM or to targets 6 and 7) never gets 010, even with `defer_en_i` high.
- R8: In every other case, a write (`req_write_i`=1) or a zero-length read (`req_zero_len_i`=1) gets 101 (no data).
- R9: In every other case, a read with data gets 111 (normal data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A transaction is presented this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_zero_len_i | input | 1 | The read transfers no data |
| req_target_i | input | 3 | Target class, encoded as in R3 |
| req_lock_i | input | 1 | Locked transaction |
| snoop_hitm_i | input | 1 | The snoop hit a modified line |
| target_busy_i | input | 1 | The target cannot be reached now |
| defer_en_i | input | 1 | Deferral is allowed |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_code_o | output | 3 | Response code |

## Verification
The assertions check the following on every cycle:
- the strobe tracks the request one cycle later;
- idle is the code whenever the strobe is low;
- the reserved and hard-failure codes never appear;
- retry only follows a busy target;
- deferral only follows an asserted enable;
- a snoop hit on a free target always yields implicit writeback.

Some properties need a chosen target, direction and lock combination, so only the bench scenarios can show them. These are:
- which targets qualify for retry and for deferral;
- that busy DRAM writes fall through;
- the split between no-data and normal-data responses.

A full sweep of all input combinations compares every response with a model built from the requirements.

// File: rtl/host_resp_pkg.sv
package host_resp_pkg;
  localparam int TGT_W   = 3;
  localparam int NUM_TGT = 1 << TGT_W;
  localparam int CODE_W  = 3;

  localparam logic [CODE_W-1:0] RSP_IDLE   = 3'b000;
  localparam logic [CODE_W-1:0] RSP_RETRY  = 3'b001;
  localparam logic [CODE_W-1:0] RSP_DEFER  = 3'b010;
  localparam logic [CODE_W-1:0] RSP_RSVD   = 3'b011;
  localparam logic [CODE_W-1:0] RSP_HARD   = 3'b100;
  localparam logic [CODE_W-1:0] RSP_NODATA = 3'b101;
  localparam logic [CODE_W-1:0] RSP_IWB    = 3'b110;
  localparam logic [CODE_W-1:0] RSP_DATA   = 3'b111;

  localparam int TGT_DRAM = 0;

  // bit i set: target class i qualifies
  localparam logic [NUM_TGT-1:0] RETRY_RD_MASK = 8'b0011_1110;
  localparam logic [NUM_TGT-1:0] RETRY_WR_MASK = 8'b0011_1110;
  localparam logic [NUM_TGT-1:0] DEFER_RD_MASK = 8'b0011_1110;
  localparam logic [NUM_TGT-1:0] DEFER_WR_MASK = 8'b0010_0100;
endpackage

// File: rtl/host_resp_elig.sv
module host_resp_elig
  import host_resp_pkg::*;
(
  input  logic [TGT_W-1:0] target_i,
  input  logic             write_i,
  input  logic             lock_i,
  output logic             retry_ok_o,
  output logic             defer_ok_o
);
  logic [NUM_TGT-1:0] tgt_hot;
  logic [NUM_TGT-1:0] retry_hit;
  logic [NUM_TGT-1:0] defer_hit;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    assign tgt_hot[g]   = (target_i == TGT_W'(g));
    assign retry_hit[g] = tgt_hot[g] & (write_i ? RETRY_WR_MASK[g] : RETRY_RD_MASK[g]);
    assign defer_hit[g] = tgt_hot[g] & (write_i ? DEFER_WR_MASK[g] : DEFER_RD_MASK[g]);
  end

  // locked DRAM reads are the only retryable DRAM accesses
  logic dram_lock_rd;
  assign dram_lock_rd = tgt_hot[TGT_DRAM] & lock_i & ~write_i;

  assign retry_ok_o = (|retry_hit) | dram_lock_rd;
  assign defer_ok_o = |defer_hit;

  always_comb begin
    a_r3_onehot_decode: assert ($onehot(tgt_hot));
  end
endmodule

// File: rtl/host_resp_prio.sv
module host_resp_prio
  import host_resp_pkg::*;
(
  input  logic              write_i,
  input  logic              zero_len_i,
  input  logic              busy_i,
  input  logic              hitm_i,
  input  logic              defer_en_i,
  input  logic              retry_ok_i,
  input  logic              defer_ok_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    if (busy_i && retry_ok_i)         code_o = RSP_RETRY;
    else if (hitm_i)                  code_o = RSP_IWB;
    else if (defer_en_i && defer_ok_i) code_o = RSP_DEFER;
    else if (write_i || zero_len_i)   code_o = RSP_NODATA;
    else                              code_o = RSP_DATA;
  end
endmodule

// File: rtl/host_resp_enc.sv
module host_resp_enc
  import host_resp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_zero_len_i,
  input  logic [TGT_W-1:0]  req_target_i,
  input  logic              req_lock_i,
  input  logic              snoop_hitm_i,
  input  logic              target_busy_i,
  input  logic              defer_en_i,
  output logic              resp_valid_o,
  output logic [CODE_W-1:0] resp_code_o
);
  logic              retry_ok, defer_ok;
  logic [CODE_W-1:0] code_d;

  host_resp_elig u_elig (
    .target_i   (req_target_i),
    .write_i    (req_write_i),
    .lock_i     (req_lock_i),
    .retry_ok_o (retry_ok),
    .defer_ok_o (defer_ok)
  );

  host_resp_prio u_prio (
    .write_i    (req_write_i),
    .zero_len_i (req_zero_len_i),
    .busy_i     (target_busy_i),
    .hitm_i     (snoop_hitm_i),
    .defer_en_i (defer_en_i),
    .retry_ok_i (retry_ok),
    .defer_ok_i (defer_ok),
    .code_o     (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_code_o  <= RSP_IDLE;
    end else begin
      resp_valid_o <= req_valid_i;
      resp_code_o  <= req_valid_i ? code_d : RSP_IDLE;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  a_r1_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!resp_valid_o && resp_code_o == RSP_IDLE));
  a_r2_no_rsvd_hard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_code_o != RSP_RSVD) && (resp_code_o != RSP_HARD));
  a_r3_retry_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_code_o == RSP_RETRY) |-> $past(target_busy_i));
  a_r5_hitm_free_iwb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && snoop_hitm_i && !target_busy_i) |=> resp_code_o == RSP_IWB);
  a_r6_defer_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_code_o == RSP_DEFER) |-> $past(defer_en_i && !snoop_hitm_i));
endmodule

// File: tb/host_resp_enc_tb.sv
module host_resp_enc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v = 1'b0, w = 1'b0, zl = 1'b0, lk = 1'b0, hm = 1'b0, bz = 1'b0, de = 1'b0;
  logic [2:0] tg = 3'd0;
  logic       rv;
  logic [2:0] rc;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  host_resp_enc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_write_i(w),
    .req_zero_len_i(zl), .req_target_i(tg), .req_lock_i(lk),
    .snoop_hitm_i(hm), .target_busy_i(bz), .defer_en_i(de),
    .resp_valid_o(rv), .resp_code_o(rc)
  );

  function automatic logic [2:0] model(logic [2:0] t, logic wr, logic z, logic l,
                                       logic h, logic b, logic d);
    logic r_ok, d_ok;
    r_ok = (t >= 3'd1 && t <= 3'd5) || (t == 3'd0 && l && !wr);
    d_ok = wr ? (t == 3'd2 || t == 3'd5) : (t >= 3'd1 && t <= 3'd5);
    if (b && r_ok)      return 3'b001;
    else if (h)         return 3'b110;
    else if (d && d_ok) return 3'b010;
    else if (wr || z)   return 3'b101;
    else                return 3'b111;
  endfunction

  task automatic check(string tag, logic ev, logic [2:0] ec);
    checks++;
    if (rv !== ev || rc !== ec) begin
      errors++;
      $display("FAIL %s: valid=%0b code=%03b expected valid=%0b code=%03b", tag, rv, rc, ev, ec);
    end
  endtask

  // drive at negedge, capture at posedge, sample at next negedge
  task automatic issue(logic [2:0] t, logic wr, logic z, logic l, logic h, logic b, logic d);
    v = 1'b1; tg = t; w = wr; zl = z; lk = l; hm = h; bz = b; de = d;
    @(negedge clk);
  endtask

  task automatic run(string tag, logic [2:0] t, logic wr, logic z, logic l,
                     logic h, logic b, logic d, logic [2:0] ec);
    issue(t, wr, z, l, h, b, d);
    check(tag, 1'b1, ec);
  endtask

  task automatic t_reset;
    check("R1 reset", 1'b0, 3'b000);
  endtask

  task automatic t_idle;
    run("R1 valid", 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111);
    v = 1'b0; w = 1'b1; bz = 1'b1;
    @(negedge clk);
    check("R1 idle", 1'b0, 3'b000);
  endtask

  task automatic t_retry;
    run("R3 pci mem rd", 3'd1, 0, 0, 0, 0, 1, 0, 3'b001);
    run("R3 pci io wr",  3'd2, 1, 0, 0, 1, 1, 1, 3'b001);
    run("R3 agp mem wr", 3'd4, 1, 0, 0, 0, 1, 0, 3'b001);
    run("R3 dram lock rd", 3'd0, 0, 0, 1, 0, 1, 0, 3'b001);
  endtask

  task automatic t_fallthrough;
    run("R4 dram rd",      3'd0, 0, 0, 0, 0, 1, 1, 3'b111);
    run("R4 dram lock wr", 3'd0, 1, 0, 1, 0, 1, 0, 3'b101);
    run("R4 tgt7 rd",      3'd7, 0, 0, 0, 1, 1, 0, 3'b110);
  endtask

  task automatic t_hitm;
    run("R5 hitm dram", 3'd0, 0, 0, 0, 1, 0, 1, 3'b110);
    run("R5 hitm pci",  3'd1, 0, 0, 0, 1, 0, 1, 3'b110);
  endtask

  task automatic t_defer;
    run("R6 inta rd",   3'd3, 0, 0, 0, 0, 0, 1, 3'b010);
    run("R6 agp io wr", 3'd5, 1, 0, 0, 0, 0, 1, 3'b010);
    run("R6 agp mem rd", 3'd4, 0, 1, 0, 0, 0, 1, 3'b010);
  endtask

  task automatic t_no_defer;
    run("R7 pci mem wr", 3'd1, 1, 0, 0, 0, 0, 1, 3'b101);
    run("R7 agp mem wr", 3'd4, 1, 0, 0, 0, 0, 1, 3'b101);
    run("R7 dram rd",    3'd0, 0, 0, 0, 0, 0, 1, 3'b111);
  endtask

  task automatic t_nodata;
    run("R8 dram wr",  3'd0, 1, 0, 0, 0, 0, 0, 3'b101);
    run("R8 zl rd",    3'd1, 0, 1, 0, 0, 0, 0, 3'b101);
  endtask

  task automatic t_normal;
    run("R9 dram rd",  3'd0, 0, 0, 0, 0, 0, 0, 3'b111);
    run("R9 pci io rd", 3'd2, 0, 0, 1, 0, 0, 0, 3'b111);
  endtask

  task automatic t_sweep;
    for (int t = 0; t < 8; t++) begin
      for (int m = 0; m < 64; m++) begin
        logic [5:0] b;
        logic [2:0] e;
        b = 6'(m);
        e = model(3'(t), b[0], b[1], b[2], b[3], b[4], b[5]);
        issue(3'(t), b[0], b[1], b[2], b[3], b[4], b[5]);
        check("R2 sweep", 1'b1, e);
        if (rc == 3'b011 || rc == 3'b100) begin
          errors++;
          $display("FAIL R2: code=%03b expected not 011/100", rc);
        end
      end
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_idle();
    t_retry();
    t_fallthrough();
    t_hitm();
    t_defer();
    t_no_defer();
    t_nodata();
    t_normal();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule